// File: doc/BRIEF.md
# Two-Coin Beverage Dispenser Controller

This block is the control state machine of a drink vending unit. Each coin the mechanism accepts arrives as a one-cycle pulse. The controller needs two such coins before it takes a product choice from one of three selection strobes. It then issues a one-cycle dispense command on the matching line and waits until the customer removes the bottle. A jam sensor overrides everything else. While it is active, the controller refuses coins and does not dispense. When the jam clears, any credit is lost and the controller returns to waiting for money.

There are five named states:

| State | Status code | Meaning |
|-------|-------------|---------|
| IDLE | 0 | No credit |
| ONE | 1 | One coin held |
| TWO | 2 | Paid, waiting for a choice |
| WAIT | 3 | Product dispensed, waiting for the bottle to be taken |
| JAM | 4 | Fault |

The transitions are:

- coin_first: IDLE to ONE.
- coin_second: ONE to TWO.
- vend: TWO to WAIT.
- collect: WAIT to IDLE.
- jam_hit: any state to JAM.
- jam_clear: JAM to IDLE.

All outputs are registered from the state, as in a Moore machine. The state code is brought out on a status port.

Top module: `vend_ctrl`

## Requirements
- R1: Reset is synchronous and active high. The cycle after reset is sampled shows status 0 (IDLE), `coin_en_o`=1, `disp_o`=0 and `coin_rej_o`=0.
- R2: A quarter pulse with jam low takes IDLE (0) to ONE (1), and ONE to TWO (2). With no quarter, IDLE and ONE hold.
- R3: In TWO with jam low, any asserted selection moves the controller to WAIT (3). `disp_o` has exactly the bit of the lowest-numbered asserted selection set (bit i for `sel_i[i]`). With no selection, TWO holds.
- R4: The dispense output is high only in the first cycle of WAIT that follows TWO. In every other cycle it is zero.
- R5: WAIT holds until `taken_i` is high with jam low, and then goes to IDLE.
- R6: `jam_i` high in any state sends the controller to JAM (4) in the next cycle. It overrides every other input in that cycle, so no credit and no dispense results.
- R7: JAM holds while `jam_i` is high. When `jam_i` is low, JAM goes to IDLE, and all earlier credit is lost.
- R8: `coin_en_o` is high exactly when the status is IDLE or ONE.
- R9: A quarter pulse that is not credited produces a one-cycle `coin_rej_o` pulse in the next cycle. A quarter is not credited when the state is TWO, WAIT or JAM, or when jam is high in the same cycle. Credited quarters never produce a pulse.
- R10: A selection outside TWO, and `taken_i` outside WAIT, have no effect on the state or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| quarter_i | input | 1 | One-cycle pulse: one coin accepted by the mechanism |
| sel_i | input | NUM_SEL | Product selection strobes; bit 0 has the highest priority |
| taken_i | input | 1 | Bottle removed by the customer |
| jam_i | input | 1 | Jam sensor, active high |
| disp_o | output | NUM_SEL | One-hot dispense pulse |
| coin_en_o | output | 1 | Coin mechanism may accept money |
| coin_rej_o | output | 1 | One-cycle pulse for a quarter that was not credited |
| state_o | output | 3 | Current state code (0 to 4) |

## Verification
Two functions can act in the same cycle. One is the jam override. The other is whichever normal action the current state offers: a credited quarter, a vend, or a collection. The bench places the controller in each of the five states. In each state it applies every combination of quarter, the three selections, taken and jam for one cycle. A model computed from the requirements predicts the next state and the outputs for each case. With jam high, the bench must observe JAM with no dispense. Any quarter in that cycle must show up as rejected.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_ONE  = 3'd1,
        ST_TWO  = 3'd2,
        ST_WAIT = 3'd3,
        ST_JAM  = 3'd4
    } vend_state_e;

    // States in which a quarter pulse adds credit
    function automatic logic takes_coin(vend_state_e s);
        return (s == ST_IDLE) || (s == ST_ONE);
    endfunction

endpackage

// File: rtl/vend_sel_prio.sv
module vend_sel_prio #(
    parameter int NUM_SEL = 3
) (
    input  logic [NUM_SEL-1:0] req_i,
    output logic [NUM_SEL-1:0] grant_o,
    output logic               any_o
);

    logic [NUM_SEL:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_prio
        assign grant_o[i]  = req_i[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req_i[i];
    end

    assign any_o = seen[NUM_SEL];

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        quarter_i,
    input  logic        sel_any_i,
    input  logic        taken_i,
    input  logic        jam_i,
    output vend_state_e state_q_o,
    output vend_state_e state_d_o
);

    vend_state_e state_q;
    vend_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (jam_i) begin
            state_d = ST_JAM;              // jam_hit
        end else begin
            unique case (state_q)
                ST_IDLE: if (quarter_i) state_d = ST_ONE;  // coin_first
                ST_ONE:  if (quarter_i) state_d = ST_TWO;  // coin_second
                ST_TWO:  if (sel_any_i) state_d = ST_WAIT; // vend
                ST_WAIT: if (taken_i)   state_d = ST_IDLE; // collect
                ST_JAM:  state_d = ST_IDLE;                // jam_clear
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign state_q_o = state_q;
    assign state_d_o = state_d;

endmodule

// File: rtl/vend_out.sv
module vend_out
    import vend_pkg::*;
#(
    parameter int NUM_SEL = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  vend_state_e        state_q_i,
    input  vend_state_e        state_d_i,
    input  logic               quarter_i,
    input  logic               jam_i,
    input  logic [NUM_SEL-1:0] grant_i,
    output logic [NUM_SEL-1:0] disp_o,
    output logic               coin_en_o,
    output logic               coin_rej_o
);

    logic vend_entry;
    logic credited;

    assign vend_entry = (state_q_i == ST_TWO) && (state_d_i == ST_WAIT);
    assign credited   = takes_coin(state_q_i) && !jam_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            disp_o     <= '0;
            coin_en_o  <= 1'b1;
            coin_rej_o <= 1'b0;
        end else begin
            disp_o     <= vend_entry ? grant_i : '0;
            coin_en_o  <= takes_coin(state_d_i);
            coin_rej_o <= quarter_i && !credited;
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int NUM_SEL = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               quarter_i,
    input  logic [NUM_SEL-1:0] sel_i,
    input  logic               taken_i,
    input  logic               jam_i,
    output logic [NUM_SEL-1:0] disp_o,
    output logic               coin_en_o,
    output logic               coin_rej_o,
    output logic [2:0]         state_o
);

    logic [NUM_SEL-1:0] grant;
    logic               sel_any;
    vend_state_e        state_q;
    vend_state_e        state_d;

    vend_sel_prio #(.NUM_SEL(NUM_SEL)) prio_i (
        .req_i   (sel_i),
        .grant_o (grant),
        .any_o   (sel_any)
    );

    vend_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .quarter_i (quarter_i),
        .sel_any_i (sel_any),
        .taken_i   (taken_i),
        .jam_i     (jam_i),
        .state_q_o (state_q),
        .state_d_o (state_d)
    );

    vend_out #(.NUM_SEL(NUM_SEL)) out_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .state_q_i  (state_q),
        .state_d_i  (state_d),
        .quarter_i  (quarter_i),
        .jam_i      (jam_i),
        .grant_i    (grant),
        .disp_o     (disp_o),
        .coin_en_o  (coin_en_o),
        .coin_rej_o (coin_rej_o)
    );

    assign state_o = state_q;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int NUM_SEL = 3
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               quarter_i,
    input logic [NUM_SEL-1:0] sel_i,
    input logic               taken_i,
    input logic               jam_i,
    input logic [NUM_SEL-1:0] disp_o,
    input logic               coin_en_o,
    input logic               coin_rej_o,
    input logic [2:0]         state_o
);

    localparam logic [2:0] C_IDLE = 3'd0;
    localparam logic [2:0] C_ONE  = 3'd1;
    localparam logic [2:0] C_TWO  = 3'd2;
    localparam logic [2:0] C_WAIT = 3'd3;
    localparam logic [2:0] C_JAM  = 3'd4;

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        rst_i |=> (state_o == C_IDLE) && coin_en_o && (disp_o == '0)); // R1

    AST_SECOND_COIN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == C_ONE) && quarter_i && !jam_i |=> state_o == C_TWO); // R2

    AST_DISP_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(disp_o)); // R3

    AST_DISP_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == C_TWO) && !jam_i && (|sel_i) |=> (state_o == C_WAIT) && ($countones(disp_o) == 1)); // R4

    AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == C_WAIT) && !taken_i && !jam_i |=> (state_o == C_WAIT) && (disp_o == '0)); // R5

    AST_JAM_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        jam_i |=> (state_o == C_JAM) && (disp_o == '0)); // R6

    AST_JAM_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == C_JAM) && !jam_i |=> state_o == C_IDLE); // R7

    AST_COIN_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        coin_en_o == ((state_o == C_IDLE) || (state_o == C_ONE))); // R8

    AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        quarter_i && ((state_o == C_TWO) || (state_o == C_WAIT) || (state_o == C_JAM)) |=> coin_rej_o); // R9

endmodule

bind vend_ctrl vend_ctrl_chk #(.NUM_SEL(NUM_SEL)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .quarter_i  (quarter_i),
    .sel_i      (sel_i),
    .taken_i    (taken_i),
    .jam_i      (jam_i),
    .disp_o     (disp_o),
    .coin_en_o  (coin_en_o),
    .coin_rej_o (coin_rej_o),
    .state_o    (state_o)
);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       quarter;
    logic [2:0] sel;
    logic       taken;
    logic       jam;
    logic [2:0] disp;
    logic       coin_en;
    logic       coin_rej;
    logic [2:0] state;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    vend_ctrl #(.NUM_SEL(3)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .quarter_i  (quarter),
        .sel_i      (sel),
        .taken_i    (taken),
        .jam_i      (jam),
        .disp_o     (disp),
        .coin_en_o  (coin_en),
        .coin_rej_o (coin_rej),
        .state_o    (state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic apply(input logic q, input logic [2:0] s, input logic t, input logic j);
        @(negedge clk);
        quarter = q; sel = s; taken = t; jam = j;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; quarter = 0; sel = 0; taken = 0; jam = 0;
        @(posedge clk);
        @(posedge clk);
        #2;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic to_state(input int st);
        do_reset();
        case (st)
            1: apply(1, 3'b000, 0, 0);
            2: begin apply(1, 3'b000, 0, 0); apply(1, 3'b000, 0, 0); end
            3: begin apply(1, 3'b000, 0, 0); apply(1, 3'b000, 0, 0); apply(0, 3'b001, 0, 0); end
            4: apply(0, 3'b000, 0, 1);
            default: ;
        endcase
    endtask

    function automatic int exp_next(int st, bit q, logic [2:0] s, bit t, bit j);
        if (j) return 4;
        case (st)
            0: return q ? 1 : 0;
            1: return q ? 2 : 1;
            2: return (s != 0) ? 3 : 2;
            3: return t ? 0 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic string state_req(int st, bit j, logic [2:0] s, bit t);
        if (j) return "R6";
        if (st == 4) return "R7";
        if (st != 2 && s != 0) return "R10";
        if (st != 3 && t) return "R10";
        case (st)
            0, 1: return "R2";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    initial begin
        rst = 1'b1; quarter = 0; sel = 0; taken = 0; jam = 0;
        do_reset();
        // R1: reset state
        check(state == 3'd0, "R1", state, 0);
        check(coin_en == 1'b1, "R1", coin_en, 1);
        check(disp == 3'b000, "R1", disp, 0);
        check(coin_rej == 1'b0, "R1", coin_rej, 0);

        // Sweep: every start state against every one-cycle input combination
        for (int st = 0; st < 5; st++) begin
            for (int c = 0; c < 64; c++) begin
                bit         q = c[0];
                logic [2:0] s = c[3:1];
                bit         t = c[4];
                bit         j = c[5];
                int         nx;
                logic [2:0] ed;
                bit         er;
                to_state(st);
                check(state == st[2:0], "R2", state, st);
                nx = exp_next(st, q, s, t, j);
                ed = (!j && st == 2) ? (s & (~s + 3'd1)) : 3'b000;
                er = q && !((st <= 1) && !j);
                apply(q, s, t, j);
                check(state == nx[2:0], state_req(st, j, s, t), state, nx);
                check(disp == ed, (st == 2) ? "R3" : "R4", disp, ed);
                check(coin_en == (nx <= 1), "R8", coin_en, (nx <= 1));
                check(coin_rej == er, "R9", coin_rej, er);
            end
        end

        // R4: dispense lasts one cycle only
        to_state(2);
        apply(0, 3'b100, 0, 0);
        check(disp == 3'b100, "R4", disp, 4);
        apply(0, 3'b000, 0, 0);
        check(disp == 3'b000, "R4", disp, 0);
        check(state == 3'd3, "R5", state, 3);

        // R7: credit lost across jam, hold while jam high
        to_state(1);
        apply(0, 3'b000, 0, 1);
        apply(0, 3'b000, 0, 1);
        check(state == 3'd4, "R7", state, 4);
        apply(0, 3'b000, 0, 0);
        check(state == 3'd0, "R7", state, 0);
        apply(1, 3'b000, 0, 0);
        check(state == 3'd1, "R7", state, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule